// File: doc/BRIEF.md
# Amplifier Mute and Protection Controller

This block decides, one clock edge at a time, whether a stereo power stage is switched on and whether its output is silenced. It merges two mute requests, an active-low shutdown pin, an under-voltage flag, a junction-temperature reading with hysteresis, and a reference-ready flag into an amplifier enable and a mute command. It also produces a hold signal that keeps the control-register file closed to writes until the reference has settled, and a register reset that follows the supply-good input.

Each time the power stage is switched on, and each time the audio input source or the output mode changes, the mute command stays asserted for a run-time settle length before audio is released. Shutdown and thermal trips switch the stage off without disturbing the register file. Only loss of supply does that.

Top module: `amp_guard_ctrl`

## Requirements
- R1: `mute_out` is high after any clock edge at which `mute_pin` or `sw_mute` was high. Either request alone is enough.
- R2: A low `shdn_n` drives `amp_en` low and `mute_out` high at the next edge. `reg_por` and `reg_hold` keep their values while `supply_good` stays high.
- R3: When `shdn_n` returns high with the supply good, the reference ready and the die cool, `amp_en` rises at the second edge. `mute_out` falls at edge 2+max(`settle_len`,1).
- R4: A high `uv_flag` forces `mute_out` high at the next edge and leaves `amp_en` unchanged.
- R5: `temp_c` above 150 disables the stage (`amp_en` low, `mute_out` high) at the next edge. The stage stays off while the reading is 100 or higher, including exactly 150 and exactly 100. A reading below 100 re-enables the stage at the next edge through a fresh settle period.
- R6: After `supply_good` rises, `reg_hold` stays high, and `amp_en` stays low, until `bypass_ok` is seen high. `amp_en` is never high while `reg_hold` is high.
- R7: A low `supply_good` drives `reg_por`, `reg_hold` and `mute_out` high and `amp_en` low at the next edge.
- R8: The settle length is `settle_len` edges. A value of 0 behaves as 1.
- R9: A change of `src_sel` or `mode_se` while the stage is active raises `mute_out` at the next edge, with `amp_en` staying high. `mute_out` falls after `settle_len` more edges. A further change during settling restarts the count.
- R10: While `rst` is high, the outputs are `mute_out`=1, `amp_en`=0, `reg_por`=1, `reg_hold`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_good | input | 1 | Supply above the power-on threshold |
| shdn_n | input | 1 | Shutdown pin, low = off |
| mute_pin | input | 1 | External mute request, high = mute |
| sw_mute | input | 1 | Mute request from the control register, high = mute |
| mode_se | input | 1 | Output mode select (single-ended or bridged) |
| src_sel | input | SRC_W | Selected input source |
| uv_flag | input | 1 | Under-voltage detected |
| bypass_ok | input | 1 | Reference has passed its ready threshold |
| temp_c | input | TEMP_W | Junction temperature in degrees C |
| settle_len | input | CNT_W | Mute settle length in clock cycles |
| amp_en | output | 1 | Power stage enable |
| mute_out | output | 1 | Mute command |
| reg_hold | output | 1 | Block control-register writes |
| reg_por | output | 1 | Return the register file to defaults |

## Verification
A wrong internal state shows first as `amp_en` or `mute_out` at the edge after the input that should have moved it. Examples are a stage left on through a hot reading or a shutdown, or audio released early or late. The settle counter can only be seen through the edge at which `mute_out` falls, so unmute latency is measured exactly for a range of lengths and for restarts. The thermal latch is exposed by sweeping the reading up and down across both thresholds and comparing `amp_en` at every step.

// File: rtl/amp_guard_pkg.sv
package amp_guard_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT_BYP,
    ST_SETTLE,
    ST_ACTIVE,
    ST_THERM_OFF
  } guard_state_t;

endpackage

// File: rtl/amp_guard_thermal.sv
module amp_guard_thermal #(
  parameter int TEMP_W     = 8,
  parameter int HOT_LIMIT  = 150,
  parameter int COOL_LIMIT = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TEMP_W-1:0] temp_c,
  output logic              hot_now
);

  localparam logic [TEMP_W-1:0] HOT_T  = TEMP_W'(HOT_LIMIT);
  localparam logic [TEMP_W-1:0] COOL_T = TEMP_W'(COOL_LIMIT);

  logic hot_q;

  // Latched trip: set above the upper limit, released only below the lower one.
  always_comb begin
    if (hot_q) hot_now = (temp_c >= COOL_T);
    else       hot_now = (temp_c > HOT_T);
  end

  always_ff @(posedge clk) begin
    if (rst) hot_q <= 1'b0;
    else     hot_q <= hot_now;
  end

  // R5: the latch can only be set by a reading above the upper limit
  a_r5_trip_needs_hot: assert property (@(posedge clk) disable iff (rst)
    (!hot_q && temp_c <= HOT_T) |=> !hot_q);

  // R5: the latch can only be released by a reading below the lower limit
  a_r5_release_needs_cool: assert property (@(posedge clk) disable iff (rst)
    (hot_q && temp_c >= COOL_T) |=> hot_q);

endmodule

// File: rtl/amp_guard_change_det.sv
module amp_guard_change_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sig,
  output logic         changed
);

  logic [W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) last_q <= '0;
    else     last_q <= sig;
  end

  assign changed = (sig != last_q);

endmodule

// File: rtl/amp_guard_settle_timer.sv
module amp_guard_settle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] len,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_plus;

  // Zero length behaves as one cycle because cnt+1 >= 0 always holds.
  assign cnt_plus = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign done     = (cnt_plus >= {1'b0, len});

  always_ff @(posedge clk) begin
    if (rst || load)      cnt_q <= '0;
    else if (run && !done) cnt_q <= cnt_q + CNT_W'(1);
  end

  // R8: the count never runs past the programmed length while it is stable
  a_r8_count_bounded: assert property (@(posedge clk) disable iff (rst)
    (run && !load && done && $stable(len)) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/amp_guard_ctrl.sv
module amp_guard_ctrl
  import amp_guard_pkg::*;
#(
  parameter int TEMP_W     = 8,
  parameter int HOT_LIMIT  = 150,
  parameter int COOL_LIMIT = 100,
  parameter int CNT_W      = 8,
  parameter int SRC_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              supply_good,
  input  logic              shdn_n,
  input  logic              mute_pin,
  input  logic              sw_mute,
  input  logic              mode_se,
  input  logic [SRC_W-1:0]  src_sel,
  input  logic              uv_flag,
  input  logic              bypass_ok,
  input  logic [TEMP_W-1:0] temp_c,
  input  logic [CNT_W-1:0]  settle_len,
  output logic              amp_en,
  output logic              mute_out,
  output logic              reg_hold,
  output logic              reg_por
);

  localparam logic [TEMP_W-1:0] HOT_T = TEMP_W'(HOT_LIMIT);

  guard_state_t st_q, st_d;
  logic hot_now, src_chg, mode_chg, any_chg;
  logic tmr_load, tmr_done;
  logic byp_seen_q, byp_seen_d;

  amp_guard_thermal #(
    .TEMP_W(TEMP_W), .HOT_LIMIT(HOT_LIMIT), .COOL_LIMIT(COOL_LIMIT)
  ) i_thermal (
    .clk(clk), .rst(rst), .temp_c(temp_c), .hot_now(hot_now)
  );

  amp_guard_change_det #(.W(SRC_W)) i_src_chg (
    .clk(clk), .rst(rst), .sig(src_sel), .changed(src_chg)
  );

  amp_guard_change_det #(.W(1)) i_mode_chg (
    .clk(clk), .rst(rst), .sig(mode_se), .changed(mode_chg)
  );

  assign any_chg = src_chg || mode_chg;

  amp_guard_settle_timer #(.CNT_W(CNT_W)) i_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .run(st_q == ST_SETTLE),
    .len(settle_len), .done(tmr_done)
  );

  // Next-state logic: supply and shutdown override everything else.
  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    if (!supply_good || !shdn_n) begin
      st_d = ST_OFF;
    end else begin
      unique case (st_q)
        ST_OFF:      st_d = ST_WAIT_BYP;
        ST_WAIT_BYP: if (bypass_ok) begin
                       if (hot_now) st_d = ST_THERM_OFF;
                       else begin st_d = ST_SETTLE; tmr_load = 1'b1; end
                     end
        ST_SETTLE:   if (hot_now)       st_d = ST_THERM_OFF;
                     else if (any_chg)  tmr_load = 1'b1;
                     else if (tmr_done) st_d = ST_ACTIVE;
        ST_ACTIVE:   if (hot_now) st_d = ST_THERM_OFF;
                     else if (any_chg) begin st_d = ST_SETTLE; tmr_load = 1'b1; end
        ST_THERM_OFF: if (!hot_now) begin st_d = ST_SETTLE; tmr_load = 1'b1; end
        default:     st_d = ST_OFF;
      endcase
    end
  end

  always_comb begin
    if (!supply_good)   byp_seen_d = 1'b0;
    else if (bypass_ok) byp_seen_d = 1'b1;
    else                byp_seen_d = byp_seen_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_OFF;
      byp_seen_q <= 1'b0;
      amp_en     <= 1'b0;
      mute_out   <= 1'b1;
      reg_hold   <= 1'b1;
      reg_por    <= 1'b1;
    end else begin
      st_q       <= st_d;
      byp_seen_q <= byp_seen_d;
      amp_en     <= (st_d == ST_SETTLE) || (st_d == ST_ACTIVE);
      mute_out   <= (st_d != ST_ACTIVE) || mute_pin || sw_mute || uv_flag;
      reg_hold   <= !byp_seen_d;
      reg_por    <= !supply_good;
    end
  end

  a_r1_mute_merge: assert property (@(posedge clk) disable iff (rst)
    (mute_pin || sw_mute) |=> mute_out);

  a_r2_shutdown_off: assert property (@(posedge clk) disable iff (rst)
    !shdn_n |=> (!amp_en && mute_out));

  a_r2_shutdown_keeps_regs: assert property (@(posedge clk) disable iff (rst)
    (!shdn_n && supply_good && !reg_por) |=> !reg_por);

  a_r4_uv_mutes: assert property (@(posedge clk) disable iff (rst)
    uv_flag |=> mute_out);

  a_r5_hot_disables: assert property (@(posedge clk) disable iff (rst)
    (temp_c > HOT_T) |=> (!amp_en && mute_out));

  a_r6_no_enable_on_hold: assert property (@(posedge clk) disable iff (rst)
    amp_en |-> !reg_hold);

  a_r6_hold_stays_open: assert property (@(posedge clk) disable iff (rst)
    (!reg_hold && supply_good) |=> !reg_hold);

  a_r7_supply_loss: assert property (@(posedge clk) disable iff (rst)
    !supply_good |=> (reg_por && !amp_en && mute_out));

  a_r8_muted_on_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(amp_en) |-> mute_out);

endmodule

// File: tb/test_amp_guard_ctrl.sv
module test_amp_guard_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int HOT  = 150;
  localparam int COOL = 100;

  logic       clk = 1'b0;
  logic       rst, supply_good, shdn_n, mute_pin, sw_mute, mode_se;
  logic [1:0] src_sel;
  logic       uv_flag, bypass_ok;
  logic [7:0] temp_c, settle_len;
  logic       amp_en, mute_out, reg_hold, reg_por;

  int checks = 0;
  int failures = 0;

  amp_guard_ctrl i_amp_guard_ctrl (
    .clk(clk), .rst(rst), .supply_good(supply_good), .shdn_n(shdn_n),
    .mute_pin(mute_pin), .sw_mute(sw_mute), .mode_se(mode_se),
    .src_sel(src_sel), .uv_flag(uv_flag), .bypass_ok(bypass_ok),
    .temp_c(temp_c), .settle_len(settle_len), .amp_en(amp_en),
    .mute_out(mute_out), .reg_hold(reg_hold), .reg_por(reg_por)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure_unmute(output int k);
    k = 0;
    do begin
      tick();
      k++;
    end while (mute_out && k < 60);
  endtask

  initial begin
    int k;
    int exp_k;
    bit hot;
    rst = 1; supply_good = 0; shdn_n = 0; mute_pin = 0; sw_mute = 0;
    mode_se = 0; src_sel = 0; uv_flag = 0; bypass_ok = 0;
    temp_c = 25; settle_len = 3;
    repeat (3) tick();
    chk("R10 mute", mute_out, 1); chk("R10 en", amp_en, 0);
    chk("R10 por", reg_por, 1);   chk("R10 hold", reg_hold, 1);

    rst = 0; tick();
    chk("R7 por while supply low", reg_por, 1);
    chk("R7 en while supply low", amp_en, 0);

    supply_good = 1; shdn_n = 1; tick();
    chk("R7 por released", reg_por, 0);
    chk("R6 hold before bypass", reg_hold, 1);
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R6 en waits for bypass", amp_en, 0);
      chk("R6 hold waits for bypass", reg_hold, 1);
    end
    bypass_ok = 1; tick();
    chk("R6 en after bypass", amp_en, 1);
    chk("R6 hold opens", reg_hold, 0);
    chk("R3 muted while settling", mute_out, 1);
    measure_unmute(k);
    chk("R8 first settle length", k, 3);

    // Shutdown and wake-up across settle lengths (R2, R3, R8)
    for (int len = 0; len <= 6; len++) begin
      settle_len = 8'(len);
      shdn_n = 0; tick();
      chk("R2 en off", amp_en, 0);
      chk("R2 muted", mute_out, 1);
      tick();
      chk("R2 por kept", reg_por, 0);
      chk("R2 hold kept", reg_hold, 0);
      shdn_n = 1; tick();
      chk("R3 en after one edge", amp_en, 0);
      measure_unmute(k);
      exp_k = (len < 1 ? 1 : len) + 1;
      chk("R3 R8 wake latency", k + 1, exp_k + 1);
      chk("R3 en active", amp_en, 1);
    end

    // Mute sources, every combination (R1, R4)
    settle_len = 2;
    for (int m = 0; m < 8; m++) begin
      mute_pin = m[0]; sw_mute = m[1]; uv_flag = m[2];
      tick();
      chk("R1 R4 mute merge", mute_out, int'(m != 0));
      chk("R4 en kept", amp_en, 1);
      mute_pin = 0; sw_mute = 0; uv_flag = 0;
      tick();
      chk("R1 mute released", mute_out, 0);
    end

    // Source and mode changes (R9)
    settle_len = 3;
    src_sel = 1; measure_unmute(k);
    chk("R9 source change settle", k, 4);
    chk("R9 en stays", amp_en, 1);
    mode_se = 1; measure_unmute(k);
    chk("R9 mode change settle", k, 4);
    src_sel = 2; tick(); tick();
    chk("R9 muted mid settle", mute_out, 1);
    src_sel = 3; measure_unmute(k);
    chk("R9 restart on change", k, 4);

    // Thermal sweep up then down (R5)
    settle_len = 1; hot = 0;
    for (int t = 95; t <= 160; t++) begin
      temp_c = 8'(t); tick();
      if (!hot && t > HOT) hot = 1;
      chk("R5 rising en", amp_en, int'(!hot));
      if (hot) chk("R5 rising mute", mute_out, 1);
    end
    for (int t = 160; t >= 95; t--) begin
      temp_c = 8'(t); tick();
      if (hot && t < COOL) hot = 0;
      chk("R5 falling en", amp_en, int'(!hot));
      if (hot) chk("R5 falling mute", mute_out, 1);
    end
    tick();
    chk("R5 unmuted after cool", mute_out, 0);

    // Supply loss and return (R7, R6)
    supply_good = 0; tick();
    chk("R7 por on loss", reg_por, 1); chk("R7 en off", amp_en, 0);
    chk("R7 mute on loss", mute_out, 1); chk("R7 hold on loss", reg_hold, 1);
    supply_good = 1; bypass_ok = 0; tick(); tick();
    chk("R6 hold after return", reg_hold, 1); chk("R6 en after return", amp_en, 0);
    bypass_ok = 1; tick();
    chk("R6 en after bypass again", amp_en, 1);

    summary();
    $finish;
  end

endmodule